// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block holds the configuration registers of a 286-class system controller. Software reaches them through a pair of I/O ports: a write to the select port loads an 8-bit pointer, and reads and writes on the data port then reach the register that the pointer names. Only a fixed set of pointer values accepts writes. Some registers are constants. A few reads merge live status inputs into the stored bits. The stored contents of the register window from 0x40 to 0x4F leave the block as one flat vector, so that the memory-map and timing decoders downstream can use them directly.

A second port holds the fast-A20 gate and the soft-reset request. Its bit 1 drives the alternate A20 gate. When a write takes its bit 0 from 0 to 1, the block emits a reset pulse exactly one clock long. The I/O bus is a plain strobe bus, not a valid/ready stream. Each access completes in the cycle of its strobe and cannot be stalled, so there is no back-pressure. Read data is combinational and valid while the read strobe is high.

Top module: `chipset_cfg_regs`

## Requirements
- R1: A write to port 0x0022 loads the pointer. A write to port 0x0023 stores the data in the register that the pointer selects, and a read of port 0x0023 returns that register.
- R2: Only pointer values 0x41, 0x44, 0x46, 0x48, 0x49, 0x4A, 0x4B, 0x4C, 0x4D, 0x4E and 0x4F accept writes. A write through port 0x0023 at any other pointer value leaves the read-back value of that register unchanged.
- R3: A write to register 0x46 keeps only bit 6 of the data and clears the other seven bits.
- R4: After reset the registers read as follows: 0x01 is 0x00, 0x40 is 0x0A, 0x41 is 0x02, 0x44 is 0x80, 0x45 is 0x37 and 0x48 is 0xC0. Registers 0x46, 0x49, 0x4A, 0x4B, 0x4C, 0x4E and 0x4F read 0x00. Every other register holds 0xFF. Port 0x0092 reads 0x00, the A20 gate is 0 and the reset pulse is low.
- R5: A read of register 0x45 returns the stored value with bit 6 replaced by the keyboard A20 gate input.
- R6: A read of register 0x4D returns stored bits 7 and 3:0. Bits 6:5 read 0, and bit 4 reads the multi-wait status input.
- R7: The `wait_states` output is 1 when stored bits 6:4 of register 0x4D are all zero, and 2 otherwise.
- R8: Port 0x0092 reads back the last value written to it, and its bit 1 drives `a20_alt`. The new value appears on the first clock edge after the write.
- R9: A write to port 0x0092 that changes bit 0 from 0 to 1 raises `cpu_reset` for exactly one clock. A write that leaves bit 0 at 1 produces no pulse.
- R10: A read of any port other than 0x0023 and 0x0092, including the pointer port 0x0022, returns 0xFF.
- R11: Byte k of `cfg_bank` carries the stored contents of register 0x40+k, before any read merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| kbd_a20 | input | 1 | A20 gate state from the keyboard controller |
| multi_wait | input | 1 | High when more than one CPU wait state is active |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| cfg_bank | output | 128 | Stored registers 0x40 to 0x4F, byte k = register 0x40+k |
| wait_states | output | 2 | Wait-state count derived from register 0x4D |
| a20_alt | output | 1 | Alternate A20 gate |
| cpu_reset | output | 1 | One-clock soft-reset pulse |

## Verification
The bench writes to registers just outside the write list, including a constant inside the window (0x40), the status register 0x45 and a gap index (0x47). A design with too loose a decode would let these writes change what reads back. Register 0x46 is written with all ones and then with bit 6 clear, which exposes a missing or wrong write mask. The merged reads of 0x45 and 0x4D are taken with the status inputs both low and high, so a design that returns the stored bits instead of the live ones would read back the wrong value. Port 0x0092 gets a repeated 1 on bit 0 and a 1-0-1 sequence; a level-triggered or stretched reset would show as an extra pulse or a pulse lasting two cycles.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
  localparam logic [7:0] MISC_IDX = 8'h45;
  localparam logic [7:0] PWR_IDX  = 8'h46;
  localparam logic [7:0] DRAM_IDX = 8'h4D;

  // Value a register holds after reset; a non-writable index keeps it.
  function automatic logic [7:0] rst_val(input logic [7:0] idx);
    case (idx)
      8'h01:                               rst_val = 8'h00;
      8'h40:                               rst_val = 8'h0A;
      8'h41:                               rst_val = 8'h02;
      8'h44:                               rst_val = 8'h80;
      8'h45:                               rst_val = 8'h37;
      8'h48:                               rst_val = 8'hC0;
      8'h46, 8'h49, 8'h4A, 8'h4B, 8'h4C,
      8'h4E, 8'h4F:                        rst_val = 8'h00;
      default:                             rst_val = 8'hFF;
    endcase
  endfunction

  function automatic logic writable(input logic [7:0] idx);
    case (idx)
      8'h41, 8'h44, 8'h46, 8'h48, 8'h49, 8'h4A,
      8'h4B, 8'h4C, 8'h4D, 8'h4E, 8'h4F: writable = 1'b1;
      default:                           writable = 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(input logic [7:0] idx);
    wr_mask = (idx == PWR_IDX) ? 8'h40 : 8'hFF;
  endfunction
endpackage

// File: rtl/cfgrf_bank.sv
module cfgrf_bank
  import cfgrf_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h40,
  parameter int unsigned NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        sel,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] bank
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] MY = 8'(BASE + g);
    if (writable(MY)) begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= rst_val(MY);
        else if (wr_en && sel == MY)
          q <= wdata & wr_mask(MY);
      end
      assign bank[g*8 +: 8] = q;
    end else begin : g_const
      assign bank[g*8 +: 8] = rst_val(MY);
    end
  end
endmodule

// File: rtl/cfgrf_readback.sv
module cfgrf_readback
  import cfgrf_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h40,
  parameter int unsigned NREG = 16
) (
  input  logic [7:0]        sel,
  input  logic [NREG*8-1:0] bank,
  input  logic              kbd_a20,
  input  logic              multi_wait,
  output logic [7:0]        value
);
  localparam int unsigned OFF_W = $clog2(NREG);

  logic [7:0] off;
  logic [7:0] raw;

  always_comb begin
    off = sel - BASE;
    if (off < 8'(NREG))
      raw = bank[off[OFF_W-1:0]*8 +: 8];
    else
      raw = rst_val(sel);
    case (sel)
      MISC_IDX: value = {raw[7], kbd_a20, raw[5:0]};
      DRAM_IDX: value = {raw[7], 2'b00, multi_wait, raw[3:0]};
      default:  value = raw;
    endcase
  end
endmodule

// File: rtl/cfgrf_fastgate.sv
module cfgrf_fastgate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] gate_q,
  output logic       pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 8'h00;
      pulse  <= 1'b0;
    end else begin
      pulse <= wr_en && wdata[0] && !gate_q[0];
      if (wr_en)
        gate_q <= wdata;
    end
  end
endmodule

// File: rtl/chipset_cfg_regs.sv
module chipset_cfg_regs
  import cfgrf_pkg::*;
#(
  parameter logic [15:0] SEL_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [15:0] GATE_PORT = 16'h0092,
  parameter logic [7:0]  BASE      = 8'h40,
  parameter int unsigned NREG      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  input  logic              kbd_a20,
  input  logic              multi_wait,
  output logic [7:0]        io_rdata,
  output logic [NREG*8-1:0] cfg_bank,
  output logic [1:0]        wait_states,
  output logic              a20_alt,
  output logic              cpu_reset
);
  localparam int unsigned DRAM_OFF = int'(DRAM_IDX - BASE);

  logic [7:0] idx_q;
  logic [7:0] reg_val;
  logic [7:0] gate_q;
  logic       data_wr;
  logic       gate_wr;

  assign data_wr = io_wr && io_addr == DATA_PORT;
  assign gate_wr = io_wr && io_addr == GATE_PORT;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= 8'h00;
    else if (io_wr && io_addr == SEL_PORT)
      idx_q <= io_wdata;
  end

  cfgrf_bank #(.BASE(BASE), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .sel(idx_q),
    .wdata(io_wdata), .bank(cfg_bank)
  );

  cfgrf_readback #(.BASE(BASE), .NREG(NREG)) u_rb (
    .sel(idx_q), .bank(cfg_bank), .kbd_a20(kbd_a20),
    .multi_wait(multi_wait), .value(reg_val)
  );

  cfgrf_fastgate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(gate_wr), .wdata(io_wdata),
    .gate_q(gate_q), .pulse(cpu_reset)
  );

  assign a20_alt     = gate_q[1];
  assign wait_states = (cfg_bank[DRAM_OFF*8+4 +: 3] == 3'b000) ? 2'd1 : 2'd2;

  always_comb begin
    if (!io_rd)
      io_rdata = 8'hFF;
    else if (io_addr == DATA_PORT)
      io_rdata = reg_val;
    else if (io_addr == GATE_PORT)
      io_rdata = gate_q;
    else
      io_rdata = 8'hFF;
  end
endmodule

// File: rtl/cfgrf_chk.sv
module cfgrf_chk #(
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [15:0] GATE_PORT = 16'h0092,
  parameter int unsigned NREG      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       io_addr,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        idx_q,
  input logic [NREG*8-1:0] cfg_bank,
  input logic [1:0]        wait_states,
  input logic              a20_alt,
  input logic              cpu_reset
);
  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> !cpu_reset);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> $past(io_wr && io_addr == GATE_PORT && io_wdata[0]));

  // R8
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(io_wr && io_addr == GATE_PORT) |-> a20_alt == $past(io_wdata[1]));

  // R2
  const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == DATA_PORT && idx_q == 8'h40 |=> $stable(cfg_bank[7:0]));

  // R3
  pwr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == DATA_PORT && idx_q == 8'h46 |=> (cfg_bank[6*8 +: 8] & 8'hBF) == 8'h00);

  // R7
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_states == 2'd1 || wait_states == 2'd2);
endmodule

bind chipset_cfg_regs cfgrf_chk #(.DATA_PORT(DATA_PORT), .GATE_PORT(GATE_PORT), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .idx_q(idx_q), .cfg_bank(cfg_bank), .wait_states(wait_states),
  .a20_alt(a20_alt), .cpu_reset(cpu_reset)
);

// File: tb/chipset_cfg_regs_test.sv
module chipset_cfg_regs_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  io_addr = 16'h0000;
  logic         io_wr = 1'b0;
  logic         io_rd = 1'b0;
  logic [7:0]   io_wdata = 8'h00;
  logic         kbd_a20 = 1'b0;
  logic         multi_wait = 1'b0;
  logic [7:0]   io_rdata;
  logic [127:0] cfg_bank;
  logic [1:0]   wait_states;
  logic         a20_alt;
  logic         cpu_reset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chipset_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .kbd_a20(kbd_a20), .multi_wait(multi_wait),
    .io_rdata(io_rdata), .cfg_bank(cfg_bank), .wait_states(wait_states),
    .a20_alt(a20_alt), .cpu_reset(cpu_reset)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(16'h0022, idx);
    io_read(16'h0023, d);
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    io_write(16'h0022, idx);
    io_write(16'h0023, d);
  endtask

  task automatic test_reset_state();
    logic [7:0] v;
    reg_read(8'h01, v); check("R4 idx01", v, 8'h00);
    reg_read(8'h40, v); check("R4 idx40", v, 8'h0A);
    reg_read(8'h41, v); check("R4 idx41", v, 8'h02);
    reg_read(8'h44, v); check("R4 idx44", v, 8'h80);
    reg_read(8'h45, v); check("R4 idx45", v, 8'h37);
    reg_read(8'h48, v); check("R4 idx48", v, 8'hC0);
    reg_read(8'h4C, v); check("R4 idx4C", v, 8'h00);
    reg_read(8'h4D, v); check("R4 idx4D", v, 8'h8F);
    reg_read(8'h20, v); check("R4 idx20", v, 8'hFF);
    io_read(16'h0092, v); check("R4 gate port", v, 8'h00);
    check("R4 a20", {7'd0, a20_alt}, 8'h00);
    check("R4 pulse", {7'd0, cpu_reset}, 8'h00);
    check("R4 wait", {6'd0, wait_states}, 8'h02);
  endtask

  task automatic test_roundtrip();
    logic [7:0] v;
    reg_write(8'h41, 8'h5A); reg_read(8'h41, v); check("R1 idx41", v, 8'h5A);
    check("R11 bank41", cfg_bank[15:8], 8'h5A);
    reg_write(8'h4F, 8'hA5); reg_read(8'h4F, v); check("R1 idx4F", v, 8'hA5);
    check("R11 bank4F", cfg_bank[127:120], 8'hA5);
  endtask

  task automatic test_whitelist();
    logic [7:0] v;
    reg_write(8'h40, 8'h33); reg_read(8'h40, v); check("R2 idx40", v, 8'h0A);
    reg_write(8'h45, 8'h00); reg_read(8'h45, v); check("R2 idx45", v, 8'h37);
    reg_write(8'h47, 8'h00); reg_read(8'h47, v); check("R2 idx47", v, 8'hFF);
    reg_write(8'h01, 8'h77); reg_read(8'h01, v); check("R2 idx01", v, 8'h00);
    reg_write(8'h10, 8'h12); reg_read(8'h10, v); check("R2 idx10", v, 8'hFF);
  endtask

  task automatic test_pwr_mask();
    logic [7:0] v;
    reg_write(8'h46, 8'hFF); reg_read(8'h46, v); check("R3 ones", v, 8'h40);
    reg_write(8'h46, 8'hBF); reg_read(8'h46, v); check("R3 bit6 clear", v, 8'h00);
  endtask

  task automatic test_misc_merge();
    logic [7:0] v;
    kbd_a20 = 1'b1; reg_read(8'h45, v); check("R5 gate high", v, 8'h77);
    kbd_a20 = 1'b0; reg_read(8'h45, v); check("R5 gate low", v, 8'h37);
  endtask

  task automatic test_dram_and_wait();
    logic [7:0] v;
    reg_write(8'h4D, 8'h6A);
    multi_wait = 1'b0; reg_read(8'h4D, v); check("R6 mw0", v, 8'h0A);
    multi_wait = 1'b1; reg_read(8'h4D, v); check("R6 mw1", v, 8'h1A);
    check("R7 bits110", {6'd0, wait_states}, 8'h02);
    reg_write(8'h4D, 8'hF3);
    multi_wait = 1'b0; reg_read(8'h4D, v); check("R6 high bits", v, 8'h83);
    reg_write(8'h4D, 8'h0A);
    check("R7 bits000", {6'd0, wait_states}, 8'h01);
    reg_write(8'h4D, 8'h10);
    check("R7 bits001", {6'd0, wait_states}, 8'h02);
  endtask

  task automatic gate_write(input logic [7:0] d, input logic exp_pulse, input string tag);
    @(negedge clk);
    io_addr = 16'h0092; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check(tag, {7'd0, cpu_reset}, {7'd0, exp_pulse});
    @(negedge clk);
    check({tag, " end"}, {7'd0, cpu_reset}, 8'h00);
  endtask

  task automatic test_gate_port();
    logic [7:0] v;
    io_write(16'h0092, 8'h02);
    check("R8 a20 set", {7'd0, a20_alt}, 8'h01);
    io_read(16'h0092, v); check("R8 readback", v, 8'h02);
    io_write(16'h0092, 8'h00);
    check("R8 a20 clear", {7'd0, a20_alt}, 8'h00);
    gate_write(8'h01, 1'b1, "R9 rise");
    gate_write(8'h03, 1'b0, "R9 held");
    gate_write(8'h00, 1'b0, "R9 fall");
    gate_write(8'h01, 1'b1, "R9 rise again");
  endtask

  task automatic test_undecoded();
    logic [7:0] v;
    io_read(16'h0024, v); check("R10 port24", v, 8'hFF);
    io_read(16'h0093, v); check("R10 port93", v, 8'hFF);
    io_read(16'h0022, v); check("R10 port22", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_roundtrip();
    test_whitelist();
    test_pwr_mask();
    test_misc_merge();
    test_dram_and_wait();
    test_gate_port();
    test_undecoded();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule